// File: doc/BRIEF.md
# Instruction-Cycle Step Sequencer

This block paces the instruction cycle of a small accumulator machine with 16-bit instruction words. A 4-bit step counter advances once per rising clock edge. A decoder turns the counter into sixteen one-hot step strobes. Every instruction spends its first three steps on the same fetch and decode work. Step 0 moves the program counter into the address register. Step 1 reads the addressed word into the instruction register and bumps the program counter. Step 2 decodes the opcode and points the address register at the operand field.

At the step-2 edge the block captures three things from the instruction: the 3-bit opcode, expanded to one of eight one-hot lines; the top (indirect) bit; and the 12-bit address field. These values stay fixed while the instruction executes. The counter does not run free. An instruction ends when opcode line 3 coincides with step 4, or when the execution logic raises an external end request. Either event zeroes the counter at the next edge, so each instruction returns to step 0 after its own number of steps. The captured opcode, indirect bit and address are cleared at that same edge. Memory accesses are assumed to finish within one step, so the block never inserts a wait.

Top module: `instr_cycle_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has step strobe 0 active (`t_strobe` = 0x0001), `d_op` = 0, `ind_bit` = 0 and `addr_field` = 0.
- R2: Without a clear, the step count rises by one at each rising edge. `t_strobe` always has exactly one bit set: bit k for count k.
- R3: With no clear, the step after 15 is 0, so the strobes wrap from bit 15 to bit 0.
- R4: `ar_load_pc` is high exactly during step 0.
- R5: `ir_load` and `pc_inc` are high exactly during step 1.
- R6: `ar_load_addr` is high exactly during step 2.
- R7: At the edge that ends step 2, the block captures three fields from `instr`. `d_op` becomes one-hot with bit n set, where n = `instr[14:12]`. `ind_bit` takes `instr[15]`. `addr_field` takes `instr[11:0]`. All three are zero from a clear until the next such capture.
- R8: When `d_op[3]` and step 4 are both active, the next step is 0.
- R9: When `end_req` is high at a rising edge, the next step is 0 and the captured fields are zero. This takes priority over both incrementing and a capture at step 2.
- R10: `rr_instr` is high exactly when `d_op[7]` is 1 and `ind_bit` is 0.
- R11: Changes on `instr` outside the step-2 edge do not affect `d_op`, `ind_bit` or `addr_field`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction register contents |
| end_req | input | 1 | Request to end the current instruction |
| t_strobe | output | 16 | One-hot step strobes |
| d_op | output | 8 | Captured one-hot opcode |
| ind_bit | output | 1 | Captured indirect bit |
| addr_field | output | 12 | Captured address field |
| rr_instr | output | 1 | Register-reference instruction flag |
| ar_load_pc | output | 1 | Load the address register from the program counter |
| ir_load | output | 1 | Load the instruction register from memory |
| pc_inc | output | 1 | Increment the program counter |
| ar_load_addr | output | 1 | Load the address register from the address field |

## Verification
Some rules are checked by assertions at every cycle:
- the step strobes stay one-hot and the counter steps by one (or wraps) unless cleared;
- the memory read always follows the program-counter load, and the address load always follows the memory read;
- an opcode-3 step 4 or an end request always lands on step 0;
- the captured fields hold still between a capture and the next clear.

Other behaviour only shows up in the bench's scenarios:
- the exact opcode value captured;
- the full sixteen-step wrap;
- an end request that arrives at the capture edge;
- instruction changes that must be ignored after decode.

// File: rtl/seq_pkg.sv
package seq_pkg;
  parameter int SC_W   = 4;
  parameter int OPC_W  = 3;
  parameter int ADDR_W = 12;
  localparam int N_STEP  = 1 << SC_W;
  localparam int N_OP    = 1 << OPC_W;
  localparam int INSTR_W = ADDR_W + OPC_W + 1;
  // step numbers with a fixed role
  localparam int ST_PC2AR  = 0;
  localparam int ST_FETCH  = 1;
  localparam int ST_DECODE = 2;
  localparam int ST_END_OP = 4;
  // opcode lines with a fixed role
  localparam int OP_ENDS_AT4 = 3;
  localparam int OP_REGREF   = N_OP - 1;
endpackage

// File: rtl/seq_onehot_dec.sv
module seq_onehot_dec #(
  parameter int IN_W  = 4,
  parameter int OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  sel,
  output logic [OUT_N-1:0] hot
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign hot[i] = (sel == IN_W'(i));
  end
endmodule

// File: rtl/seq_step_counter.sv
module seq_step_counter #(
  parameter int SC_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  output logic [SC_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  // R2 R3
  step_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr)) |-> cnt == $past(cnt) + 1'b1);

  // R8 R9
  step_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clr)) |-> cnt == '0);
endmodule

// File: rtl/seq_op_latch.sv
module seq_op_latch #(
  parameter int N_OP   = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cap,
  input  logic [N_OP-1:0]   op_hot,
  input  logic              ind_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [N_OP-1:0]   d_q,
  output logic              ind_q,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      d_q    <= '0;
      ind_q  <= 1'b0;
      addr_q <= '0;
    end else if (cap) begin
      d_q    <= op_hot;
      ind_q  <= ind_in;
      addr_q <= addr_in;
    end
  end

  // R7
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cap) && !$past(clr)) |-> d_q == $past(op_hot));

  // R7
  op_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(d_q));
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [INSTR_W-1:0]  instr,
  input  logic                end_req,
  output logic [N_STEP-1:0]   t_strobe,
  output logic [N_OP-1:0]     d_op,
  output logic                ind_bit,
  output logic [ADDR_W-1:0]   addr_field,
  output logic                rr_instr,
  output logic                ar_load_pc,
  output logic                ir_load,
  output logic                pc_inc,
  output logic                ar_load_addr
);
  logic [SC_W-1:0] step_cnt;
  logic [N_OP-1:0] op_hot;
  logic            done_op;
  logic            step_clr;

  assign done_op  = d_op[OP_ENDS_AT4] & t_strobe[ST_END_OP];
  assign step_clr = done_op | end_req;

  seq_step_counter #(.SC_W(SC_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(step_clr), .cnt(step_cnt)
  );

  seq_onehot_dec #(.IN_W(SC_W), .OUT_N(N_STEP)) u_tdec (
    .sel(step_cnt), .hot(t_strobe)
  );

  seq_onehot_dec #(.IN_W(OPC_W), .OUT_N(N_OP)) u_odec (
    .sel(instr[ADDR_W +: OPC_W]), .hot(op_hot)
  );

  seq_op_latch #(.N_OP(N_OP), .ADDR_W(ADDR_W)) u_lat (
    .clk(clk), .rst(rst), .clr(step_clr), .cap(t_strobe[ST_DECODE]),
    .op_hot(op_hot), .ind_in(instr[INSTR_W-1]), .addr_in(instr[ADDR_W-1:0]),
    .d_q(d_op), .ind_q(ind_bit), .addr_q(addr_field)
  );

  assign ar_load_pc   = t_strobe[ST_PC2AR];
  assign ir_load      = t_strobe[ST_FETCH];
  assign pc_inc       = t_strobe[ST_FETCH];
  assign ar_load_addr = t_strobe[ST_DECODE];
  assign rr_instr     = d_op[OP_REGREF] & ~ind_bit;

  // R2
  t_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(t_strobe) == 1);

  // R5
  read_after_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (ir_load && !$past(rst)) |-> $past(ar_load_pc));

  // R6
  addr_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    (ar_load_addr && !$past(rst)) |-> $past(ir_load));

  // R8
  op3_end_chk: assert property (@(posedge clk) disable iff (rst)
    (d_op[OP_ENDS_AT4] && t_strobe[ST_END_OP]) |=> t_strobe[0]);

  // R9
  ext_end_chk: assert property (@(posedge clk) disable iff (rst)
    end_req |=> (t_strobe[0] && d_op == '0 && !ind_bit));

  // R11
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!t_strobe[ST_DECODE] && !end_req && !done_op) |=>
      ($stable(d_op) && $stable(ind_bit) && $stable(addr_field)));
endmodule

// File: tb/instr_cycle_seq_tb.sv
`timescale 1ns/1ps
module instr_cycle_seq_tb;
  typedef struct packed {
    logic [15:0] t;
    logic [7:0]  d;
    logic        ind;
    logic [11:0] addr;
    logic        rr;
    logic [3:0]  en;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = '0;
  logic        end_req = 1'b0;
  logic [15:0] t_strobe;
  logic [7:0]  d_op;
  logic        ind_bit;
  logic [11:0] addr_field;
  logic        rr_instr, ar_load_pc, ir_load, pc_inc, ar_load_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string t_tag = "R2";
  string d_tag = "R7";

  exp_t exp_q[$];
  int   m_sc = 0;
  logic [7:0]  m_d = '0;
  logic        m_ind = 1'b0;
  logic [11:0] m_addr = '0;

  always #2 clk = ~clk;

  instr_cycle_seq u_dut (
    .clk(clk), .rst(rst), .instr(instr), .end_req(end_req),
    .t_strobe(t_strobe), .d_op(d_op), .ind_bit(ind_bit), .addr_field(addr_field),
    .rr_instr(rr_instr), .ar_load_pc(ar_load_pc), .ir_load(ir_load),
    .pc_inc(pc_inc), .ar_load_addr(ar_load_addr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pop one expected item and compare with the ports
  task automatic monitor();
    exp_t e;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    chk(t_tag, 32'(t_strobe), 32'(e.t));
    chk("R4", 32'(ar_load_pc), 32'(e.en[3]));
    chk("R5", 32'({ir_load, pc_inc}), 32'({e.en[2], e.en[1]}));
    chk("R6", 32'(ar_load_addr), 32'(e.en[0]));
    chk(d_tag, 32'({d_op, ind_bit, addr_field}), 32'({e.d, e.ind, e.addr}));
    chk("R10", 32'(rr_instr), 32'(e.rr));
  endtask

  // driver: apply inputs for one edge and push the state expected after it
  task automatic cyc(logic [15:0] ins, logic er, logic r = 1'b0);
    exp_t e;
    bit clr;
    @(negedge clk);
    monitor();
    instr = ins; end_req = er; rst = r;
    clr = r || er || (m_d[3] && m_sc == 4);
    if (clr) begin
      m_sc = 0; m_d = '0; m_ind = 1'b0; m_addr = '0;
    end else begin
      if (m_sc == 2) begin
        m_d = 8'(1) << ins[14:12]; m_ind = ins[15]; m_addr = ins[11:0];
      end
      m_sc = (m_sc + 1) % 16;
    end
    e.t = 16'(1) << m_sc;
    e.d = m_d; e.ind = m_ind; e.addr = m_addr;
    e.rr = m_d[7] & ~m_ind;
    e.en = {m_sc == 0, m_sc == 1, m_sc == 1, m_sc == 2};
    exp_q.push_back(e);
  endtask

  initial begin
    // R1 reset state
    t_tag = "R1"; d_tag = "R1";
    cyc(16'h0000, 1'b0, 1'b1);
    cyc(16'h0000, 1'b0, 1'b1);
    cyc(16'h0000, 1'b0, 1'b1);
    t_tag = "R2"; d_tag = "R7";
    // R8: opcode 3 ends at step 4, direct and indirect
    t_tag = "R8";
    for (int i = 0; i < 12; i++) cyc(16'h3ABC, 1'b0);
    for (int i = 0; i < 6; i++)  cyc(16'hB001, 1'b0);
    // R3: opcode 7 indirect never clears, wraps 15 -> 0; R10 flag low
    t_tag = "R3";
    for (int i = 0; i < 20; i++) cyc(16'hF123, 1'b0);
    // R9: end request at step 5 and during a register-reference instruction
    t_tag = "R9";
    while (m_sc != 0) cyc(16'h7800, 1'b0);
    for (int i = 0; i < 5; i++) cyc(16'h7800, 1'b0);
    cyc(16'h7800, 1'b1);
    // R9: end request at step 1
    cyc(16'h5555, 1'b0);
    cyc(16'h5555, 1'b1);
    // R9: end request at the capture edge (step 2) wins over capture
    cyc(16'h6444, 1'b0);
    cyc(16'h6444, 1'b0);
    cyc(16'h6444, 1'b1);
    // R11: instruction changes after decode are ignored
    t_tag = "R2"; d_tag = "R11";
    cyc(16'h1005, 1'b0);
    cyc(16'h1005, 1'b0);
    cyc(16'h1005, 1'b0);
    for (int i = 0; i < 4; i++) cyc(16'h3FFF ^ 16'(i), 1'b0);
    cyc(16'h3FFF, 1'b1);
    d_tag = "R7";
    for (int i = 0; i < 8; i++) cyc(16'h2222, 1'b0);
    cyc(16'h0000, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R2: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule